// File: doc/BRIEF.md
# Processor Execution Trace Encoder

This block watches a processor core's per-cycle activity and turns it into a binary trace stream. The activity it sees is instruction stalls and retirements, the two phases of the end-of-run secure wipe, register-file reads and writes, and data-memory loads and stores. Each cycle in which anything happens produces exactly one record. Quiet cycles produce nothing. Every record is stamped with a free-running cycle count.

A record is a burst of beats on a valid/ready stream. The header beats come first, then one body beat per register or memory event. A last flag closes the burst. Whole records wait in a small FIFO. A record that arrives while the FIFO is full is dropped and a sticky overflow flag is raised. The encoder does not judge whether the core behaved. A cycle with several headers, or with none, is still encoded as it was seen. The only anomaly it marks is a store whose byte mask is neither a full-width write nor one aligned 32-bit word.

The block sits beside the core in simulation or in an on-chip trace path. The trace consumer reassembles instruction histories: zero or more stall records, then one execute record for each instruction.

Top module: `trace_encoder`

## Requirements
- R1: After reset, trc_valid_o and ovf_o are 0 and the cycle counter is 0. The counter advances by one on each clock edge after reset is released.
- R2: Each cycle with at least one asserted event input produces exactly one record. Every beat of that record carries in trc_cycle_o the counter value of that cycle. A cycle with no events produces no record.
- R3: Header beats have trc_hdr_o=1. Their codes are stall 00, execute 01, wipe busy 10 and wipe done 11. Stall and execute beats carry the PC in trc_addr_o and the instruction word in trc_aux_o. Wipe beats carry all-zero addr, aux and data.
- R4: Each asserted header input gives its own header beat, in code order. A record with no header input holds only body beats.
- R5: Body beats follow the headers in this order: read ports by index, write ports by index, load, store. Register beats use code 01 and memory beats use code 10. trc_dir_o is 0 for read/load and 1 for write/store. Register beats put the register id in trc_addr_o and have trc_wide_o=0.
- R6: Register id bits [6:5] give the class: 0 base, 1 wide, 2 accumulator, 3 flag group. Base values are cut to 32 bits and flag values to 4 bits (C, M, L, Z). Wide and accumulator values pass unchanged.
- R7: A load, or a store whose byte mask is all ones, gives trc_wide_o=1 with the address and full data unchanged.
- R8: A store whose mask is exactly 4'hF at byte group k gives trc_wide_o=0, address plus 4*k, and data word k in bits [31:0].
- R9: Any other store mask gives trc_err_o=1, with the mask in trc_aux_o and the full data. trc_err_o is 0 on every other beat.
- R10: trc_last_o is 1 only on the final beat of a record. A beat offered while trc_ready_i is 0 holds all its fields until it is accepted.
- R11: The FIFO holds DEPTH records. A record that arrives while the FIFO is full is dropped and ovf_o is set. ovf_o stays set until ovf_clr_i is pulsed, and a new overflow in the same cycle wins over the clear.
- R12: Records leave in the order they were captured, whatever the backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stall_i | input | 1 | Instruction stalled this cycle |
| retire_i | input | 1 | Instruction retired this cycle |
| wipe_busy_i | input | 1 | Secure wipe in progress |
| wipe_done_i | input | 1 | Secure wipe completed |
| pc_i | input | XW | PC of stalled/retiring instruction |
| insn_i | input | XW | Raw instruction word |
| rd_valid_i | input | NRD | Register read strobes |
| rd_id_i | input | NRD x IDW | Register read ids |
| rd_data_i | input | NRD x WLEN | Register read values |
| wr_valid_i | input | NWR | Register write strobes |
| wr_id_i | input | NWR x IDW | Register write ids |
| wr_data_i | input | NWR x WLEN | Register write values |
| ld_valid_i | input | 1 | Memory load strobe |
| ld_addr_i | input | AW | Load address |
| ld_data_i | input | WLEN | Load data |
| st_valid_i | input | 1 | Memory store strobe |
| st_addr_i | input | AW | Store address (wide aligned) |
| st_mask_i | input | WLEN/8 | Store byte mask |
| st_data_i | input | WLEN | Store data |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| ovf_o | output | 1 | Sticky overflow flag |
| trc_valid_o | output | 1 | Beat valid |
| trc_ready_i | input | 1 | Beat accepted |
| trc_last_o | output | 1 | Final beat of record |
| trc_hdr_o | output | 1 | Header beat |
| trc_code_o | output | 2 | Item code |
| trc_dir_o | output | 1 | Write/store direction |
| trc_err_o | output | 1 | Malformed store mask |
| trc_wide_o | output | 1 | Full-width memory beat |
| trc_cycle_o | output | CW | Cycle stamp |
| trc_addr_o | output | AW | PC, address or register id |
| trc_aux_o | output | AUXW | Instruction word or bad mask |
| trc_data_o | output | WLEN | Value |

## Verification
The bench targets cycles that assert several header inputs together. An encoder that prioritises headers would drop all but one, and one that misorders them would break the stall/execute pairing. Stores are driven with a full mask, one aligned word and a two-word mask. A classifier that is wrong would mis-offset the narrow address, fail to extract the right word, or let the bad mask through with no error flag. Register values of base and flag classes carry set upper bits, so missing clipping shows up as wrong data. The FIFO is pushed one record past full with the stream stalled, and then drained. A design that overwrote stored entries, cleared the flag on its own, or reordered entries would show wrong stamps or a wrong flag.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam logic [1:0] HDR_STALL = 2'd0;
  localparam logic [1:0] HDR_EXEC  = 2'd1;
  localparam logic [1:0] HDR_WBUSY = 2'd2;
  localparam logic [1:0] HDR_WDONE = 2'd3;
  localparam logic [1:0] BODY_REG  = 2'd1;
  localparam logic [1:0] BODY_MEM  = 2'd2;
  localparam logic [1:0] CLS_BASE  = 2'd0;
  localparam logic [1:0] CLS_WIDE  = 2'd1;
  localparam logic [1:0] CLS_ACC   = 2'd2;
  localparam logic [1:0] CLS_FLAG  = 2'd3;
endpackage

// File: rtl/trace_cyc_cnt.sv
module trace_cyc_cnt #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/trace_rec_fifo.sv
module trace_rec_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (PW+1)'(DEPTH));
  assign rdata_o = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= nxt(wp_q);
      if (pop_i)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + (PW+1)'(push_i) - (PW+1)'(pop_i);
    end
  end
endmodule

// File: rtl/trace_store_class.sv
module trace_store_class #(
  parameter int WLEN = 256,
  parameter int AW   = 32,
  parameter int AUXW = 32
) (
  input  logic [WLEN/8-1:0] mask_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WLEN-1:0]   data_i,
  output logic              wide_o,
  output logic              err_o,
  output logic [AW-1:0]     addr_o,
  output logic [WLEN-1:0]   data_o,
  output logic [AUXW-1:0]   aux_o
);
  localparam int MBW = WLEN / 8;
  localparam int NW  = WLEN / 32;

  logic hit;
  int   kk;

  always_comb begin
    hit = 1'b0;
    kk  = 0;
    for (int w = 0; w < NW; w++) begin
      if (mask_i == (MBW'(4'hF) << (4 * w))) begin
        hit = 1'b1;
        kk  = w;
      end
    end
    wide_o = 1'b0;
    err_o  = 1'b0;
    addr_o = addr_i;
    data_o = data_i;
    aux_o  = '0;
    if (&mask_i) begin
      wide_o = 1'b1;
    end else if (hit) begin
      addr_o = addr_i + AW'(4 * kk);
      data_o = WLEN'(data_i[32*kk +: 32]);
    end else begin
      err_o = 1'b1;
      aux_o = AUXW'(mask_i);
    end
  end
endmodule

// File: rtl/trace_beat_sel.sv
module trace_beat_sel
  import trace_pkg::*;
#(
  parameter int NRD  = 2,
  parameter int NWR  = 2,
  parameter int XW   = 32,
  parameter int AW   = 32,
  parameter int CW   = 32,
  parameter int IDW  = 7,
  parameter int WLEN = 256,
  parameter int AUXW = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ent_valid_i,
  input  logic [3:0]                hdr_i,
  input  logic [XW-1:0]             pc_i,
  input  logic [XW-1:0]             insn_i,
  input  logic [CW-1:0]             cyc_i,
  input  logic [NRD-1:0]            rd_v_i,
  input  logic [NRD-1:0][IDW-1:0]   rd_id_i,
  input  logic [NRD-1:0][WLEN-1:0]  rd_data_i,
  input  logic [NWR-1:0]            wr_v_i,
  input  logic [NWR-1:0][IDW-1:0]   wr_id_i,
  input  logic [NWR-1:0][WLEN-1:0]  wr_data_i,
  input  logic                      ld_v_i,
  input  logic [AW-1:0]             ld_addr_i,
  input  logic [WLEN-1:0]           ld_data_i,
  input  logic                      st_v_i,
  input  logic [AW-1:0]             st_addr_i,
  input  logic [WLEN/8-1:0]         st_mask_i,
  input  logic [WLEN-1:0]           st_data_i,
  input  logic                      ready_i,
  output logic                      pop_o,
  output logic                      valid_o,
  output logic                      last_o,
  output logic                      hdr_o,
  output logic [1:0]                code_o,
  output logic                      dir_o,
  output logic                      err_o,
  output logic                      wide_o,
  output logic [CW-1:0]             cycle_o,
  output logic [AW-1:0]             addr_o,
  output logic [AUXW-1:0]           aux_o,
  output logic [WLEN-1:0]           data_o
);
  localparam int NS = 4 + NRD + NWR + 2;
  localparam int SW = $clog2(NS);
  localparam int LD_SLOT = NS - 2;
  localparam int ST_SLOT = NS - 1;

  logic [NS-1:0] act, pend, done_q, cur_oh;
  logic [SW-1:0] cur;
  logic          fire;

  logic            st_wide, st_err;
  logic [AW-1:0]   st_addr;
  logic [WLEN-1:0] st_data;
  logic [AUXW-1:0] st_aux;

  trace_store_class #(.WLEN(WLEN), .AW(AW), .AUXW(AUXW)) u_stc (
    .mask_i(st_mask_i), .addr_i(st_addr_i), .data_i(st_data_i),
    .wide_o(st_wide), .err_o(st_err), .addr_o(st_addr),
    .data_o(st_data), .aux_o(st_aux)
  );

  function automatic logic [WLEN-1:0] clip(input logic [IDW-1:0] id,
                                           input logic [WLEN-1:0] v);
    case (id[IDW-1 -: 2])
      CLS_BASE: clip = WLEN'(v[XW-1:0]);
      CLS_FLAG: clip = WLEN'(v[3:0]);
      default:  clip = v;
    endcase
  endfunction

  assign act  = {st_v_i, ld_v_i, wr_v_i, rd_v_i, hdr_i};
  assign pend = act & ~done_q;

  // lowest pending slot goes first
  always_comb begin
    cur = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (pend[i]) cur = SW'(i);
    end
  end

  assign cur_oh  = NS'(1) << cur;
  assign last_o  = ((pend & ~cur_oh) == '0);
  assign valid_o = ent_valid_i;
  assign cycle_o = cyc_i;
  assign fire    = ent_valid_i && ready_i;
  assign pop_o   = fire && last_o;

  always_comb begin
    hdr_o  = 1'b0;
    code_o = '0;
    dir_o  = 1'b0;
    err_o  = 1'b0;
    wide_o = 1'b0;
    addr_o = '0;
    aux_o  = '0;
    data_o = '0;
    if (cur < SW'(4)) begin
      hdr_o  = 1'b1;
      code_o = 2'(cur);
      if (2'(cur) == HDR_STALL || 2'(cur) == HDR_EXEC) begin
        addr_o = AW'(pc_i);
        aux_o  = AUXW'(insn_i);
      end
    end
    for (int p = 0; p < NRD; p++) begin
      if (cur == SW'(4 + p)) begin
        code_o = BODY_REG;
        addr_o = AW'(rd_id_i[p]);
        data_o = clip(rd_id_i[p], rd_data_i[p]);
      end
    end
    for (int p = 0; p < NWR; p++) begin
      if (cur == SW'(4 + NRD + p)) begin
        code_o = BODY_REG;
        dir_o  = 1'b1;
        addr_o = AW'(wr_id_i[p]);
        data_o = clip(wr_id_i[p], wr_data_i[p]);
      end
    end
    if (cur == SW'(LD_SLOT)) begin
      code_o = BODY_MEM;
      wide_o = 1'b1;
      addr_o = ld_addr_i;
      data_o = ld_data_i;
    end
    if (cur == SW'(ST_SLOT)) begin
      code_o = BODY_MEM;
      dir_o  = 1'b1;
      wide_o = st_wide;
      err_o  = st_err;
      addr_o = st_addr;
      aux_o  = st_aux;
      data_o = st_data;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     done_q <= '0;
    else if (fire)   done_q <= last_o ? '0 : (done_q | cur_oh);
  end
endmodule

// File: rtl/trace_encoder.sv
module trace_encoder #(
  parameter int NRD   = 2,
  parameter int NWR   = 2,
  parameter int XW    = 32,
  parameter int AW    = 32,
  parameter int CW    = 32,
  parameter int IDW   = 7,
  parameter int WLEN  = 256,
  parameter int DEPTH = 4,
  localparam int AUXW = (XW > WLEN / 8) ? XW : WLEN / 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      stall_i,
  input  logic                      retire_i,
  input  logic                      wipe_busy_i,
  input  logic                      wipe_done_i,
  input  logic [XW-1:0]             pc_i,
  input  logic [XW-1:0]             insn_i,
  input  logic [NRD-1:0]            rd_valid_i,
  input  logic [NRD-1:0][IDW-1:0]   rd_id_i,
  input  logic [NRD-1:0][WLEN-1:0]  rd_data_i,
  input  logic [NWR-1:0]            wr_valid_i,
  input  logic [NWR-1:0][IDW-1:0]   wr_id_i,
  input  logic [NWR-1:0][WLEN-1:0]  wr_data_i,
  input  logic                      ld_valid_i,
  input  logic [AW-1:0]             ld_addr_i,
  input  logic [WLEN-1:0]           ld_data_i,
  input  logic                      st_valid_i,
  input  logic [AW-1:0]             st_addr_i,
  input  logic [WLEN/8-1:0]         st_mask_i,
  input  logic [WLEN-1:0]           st_data_i,
  input  logic                      ovf_clr_i,
  output logic                      ovf_o,
  output logic                      trc_valid_o,
  input  logic                      trc_ready_i,
  output logic                      trc_last_o,
  output logic                      trc_hdr_o,
  output logic [1:0]                trc_code_o,
  output logic                      trc_dir_o,
  output logic                      trc_err_o,
  output logic                      trc_wide_o,
  output logic [CW-1:0]             trc_cycle_o,
  output logic [AW-1:0]             trc_addr_o,
  output logic [AUXW-1:0]           trc_aux_o,
  output logic [WLEN-1:0]           trc_data_o
);
  localparam int MBW = WLEN / 8;
  localparam int RW  = 4 + 2*XW + CW + NRD*(1+IDW+WLEN) + NWR*(1+IDW+WLEN)
                     + 1 + AW + WLEN + 1 + AW + MBW + WLEN;

  logic [CW-1:0] cyc;
  logic [3:0]    hdr_in;
  logic          any_evt, push, pop, empty, full;
  logic [RW-1:0] rec_in, rec_out;

  logic [3:0]                q_hdr;
  logic [XW-1:0]             q_pc, q_insn;
  logic [CW-1:0]             q_cyc;
  logic [NRD-1:0]            q_rd_v;
  logic [NRD-1:0][IDW-1:0]   q_rd_id;
  logic [NRD-1:0][WLEN-1:0]  q_rd_data;
  logic [NWR-1:0]            q_wr_v;
  logic [NWR-1:0][IDW-1:0]   q_wr_id;
  logic [NWR-1:0][WLEN-1:0]  q_wr_data;
  logic                      q_ld_v, q_st_v;
  logic [AW-1:0]             q_ld_addr, q_st_addr;
  logic [WLEN-1:0]           q_ld_data, q_st_data;
  logic [MBW-1:0]            q_st_mask;

  trace_cyc_cnt #(.CW(CW)) u_cnt (.clk_i(clk_i), .rst_ni(rst_ni), .cnt_o(cyc));

  assign hdr_in  = {wipe_done_i, wipe_busy_i, retire_i, stall_i};
  assign any_evt = (|hdr_in) | (|rd_valid_i) | (|wr_valid_i) | ld_valid_i | st_valid_i;
  assign push    = any_evt && !full;

  assign rec_in = {hdr_in, pc_i, insn_i, cyc,
                   rd_valid_i, rd_id_i, rd_data_i,
                   wr_valid_i, wr_id_i, wr_data_i,
                   ld_valid_i, ld_addr_i, ld_data_i,
                   st_valid_i, st_addr_i, st_mask_i, st_data_i};

  assign {q_hdr, q_pc, q_insn, q_cyc,
          q_rd_v, q_rd_id, q_rd_data,
          q_wr_v, q_wr_id, q_wr_data,
          q_ld_v, q_ld_addr, q_ld_data,
          q_st_v, q_st_addr, q_st_mask, q_st_data} = rec_out;

  trace_rec_fifo #(.W(RW), .DEPTH(DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(push), .wdata_i(rec_in),
    .pop_i(pop), .rdata_o(rec_out),
    .empty_o(empty), .full_o(full)
  );

  // overflow set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ovf_o <= 1'b0;
    else if (any_evt && full) ovf_o <= 1'b1;
    else if (ovf_clr_i)       ovf_o <= 1'b0;
  end

  trace_beat_sel #(
    .NRD(NRD), .NWR(NWR), .XW(XW), .AW(AW), .CW(CW),
    .IDW(IDW), .WLEN(WLEN), .AUXW(AUXW)
  ) u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .ent_valid_i(!empty),
    .hdr_i(q_hdr), .pc_i(q_pc), .insn_i(q_insn), .cyc_i(q_cyc),
    .rd_v_i(q_rd_v), .rd_id_i(q_rd_id), .rd_data_i(q_rd_data),
    .wr_v_i(q_wr_v), .wr_id_i(q_wr_id), .wr_data_i(q_wr_data),
    .ld_v_i(q_ld_v), .ld_addr_i(q_ld_addr), .ld_data_i(q_ld_data),
    .st_v_i(q_st_v), .st_addr_i(q_st_addr), .st_mask_i(q_st_mask),
    .st_data_i(q_st_data), .ready_i(trc_ready_i), .pop_o(pop),
    .valid_o(trc_valid_o), .last_o(trc_last_o), .hdr_o(trc_hdr_o),
    .code_o(trc_code_o), .dir_o(trc_dir_o), .err_o(trc_err_o),
    .wide_o(trc_wide_o), .cycle_o(trc_cycle_o), .addr_o(trc_addr_o),
    .aux_o(trc_aux_o), .data_o(trc_data_o)
  );
endmodule

// File: rtl/trace_encoder_chk.sv
module trace_encoder_chk #(
  parameter int AW   = 32,
  parameter int CW   = 32,
  parameter int WLEN = 256,
  parameter int AUXW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            any_evt,
  input logic            ovf_clr_i,
  input logic            ovf_o,
  input logic            trc_valid_o,
  input logic            trc_ready_i,
  input logic            trc_last_o,
  input logic            trc_hdr_o,
  input logic [1:0]      trc_code_o,
  input logic            trc_dir_o,
  input logic            trc_err_o,
  input logic            trc_wide_o,
  input logic [CW-1:0]   trc_cycle_o,
  input logic [AW-1:0]   trc_addr_o,
  input logic [AUXW-1:0] trc_aux_o,
  input logic [WLEN-1:0] trc_data_o
);
  // R10
  hold_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trc_valid_o && !trc_ready_i |=> trc_valid_o && $stable(trc_last_o) &&
      $stable(trc_hdr_o) && $stable(trc_code_o) && $stable(trc_cycle_o) &&
      $stable(trc_addr_o) && $stable(trc_aux_o) && $stable(trc_data_o));

  // R11
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !ovf_clr_i |=> ovf_o);

  // R11
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(any_evt));

  // R11
  ovf_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_clr_i && !any_evt |=> !ovf_o);

  // R9
  err_store_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trc_valid_o && trc_err_o |-> !trc_hdr_o && trc_code_o == 2'd2 && trc_dir_o && !trc_wide_o);

  // R3
  wipe_payload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trc_valid_o && trc_hdr_o && trc_code_o[1] |->
      trc_addr_o == '0 && trc_aux_o == '0 && trc_data_o == '0);

  // R8
  narrow_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trc_valid_o && !trc_hdr_o && trc_code_o == 2'd2 && !trc_wide_o && !trc_err_o |->
      trc_addr_o[1:0] == 2'b00 && trc_data_o[WLEN-1:32] == '0);
endmodule

bind trace_encoder trace_encoder_chk #(.AW(AW), .CW(CW), .WLEN(WLEN), .AUXW(AUXW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .any_evt(any_evt), .ovf_clr_i(ovf_clr_i),
  .ovf_o(ovf_o), .trc_valid_o(trc_valid_o), .trc_ready_i(trc_ready_i),
  .trc_last_o(trc_last_o), .trc_hdr_o(trc_hdr_o), .trc_code_o(trc_code_o),
  .trc_dir_o(trc_dir_o), .trc_err_o(trc_err_o), .trc_wide_o(trc_wide_o),
  .trc_cycle_o(trc_cycle_o), .trc_addr_o(trc_addr_o), .trc_aux_o(trc_aux_o),
  .trc_data_o(trc_data_o)
);

// File: tb/trace_encoder_test.sv
`timescale 1ns/1ps
module trace_encoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic stall, retire, wbusy, wdone;
  logic [31:0] pc, insn;
  logic [1:0] rd_v, wr_v;
  logic [1:0][6:0] rd_id, wr_id;
  logic [1:0][255:0] rd_data, wr_data;
  logic ld_v, st_v;
  logic [31:0] ld_addr, st_addr, st_mask;
  logic [255:0] ld_data, st_data;
  logic ovf_clr, ovf, t_valid, t_ready, t_last, t_hdr, t_dir, t_err, t_wide;
  logic [1:0] t_code;
  logic [31:0] t_cyc, t_addr, t_aux;
  logic [255:0] t_data;

  trace_encoder uut (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .retire_i(retire),
    .wipe_busy_i(wbusy), .wipe_done_i(wdone), .pc_i(pc), .insn_i(insn),
    .rd_valid_i(rd_v), .rd_id_i(rd_id), .rd_data_i(rd_data),
    .wr_valid_i(wr_v), .wr_id_i(wr_id), .wr_data_i(wr_data),
    .ld_valid_i(ld_v), .ld_addr_i(ld_addr), .ld_data_i(ld_data),
    .st_valid_i(st_v), .st_addr_i(st_addr), .st_mask_i(st_mask), .st_data_i(st_data),
    .ovf_clr_i(ovf_clr), .ovf_o(ovf), .trc_valid_o(t_valid), .trc_ready_i(t_ready),
    .trc_last_o(t_last), .trc_hdr_o(t_hdr), .trc_code_o(t_code), .trc_dir_o(t_dir),
    .trc_err_o(t_err), .trc_wide_o(t_wide), .trc_cycle_o(t_cyc), .trc_addr_o(t_addr),
    .trc_aux_o(t_aux), .trc_data_o(t_data)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] cyc = 0;
  logic [31:0] exp_cyc;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 32'd0;

  int nb;
  bit b_hdr[16], b_dir[16], b_err[16], b_wide[16], b_last[16];
  logic [1:0] b_code[16];
  logic [31:0] b_cyc[16], b_addr[16], b_aux[16];
  logic [255:0] b_data[16];

  localparam logic [255:0] D1 = {8{32'h1234abcd}} ^ {32'hcccccccc, 224'h0};
  localparam logic [255:0] D2 = {32'h00000000, 32'h00311bcb, 64'h5e157313a2fd5453, 128'hc7eb58ce1a1d070d673963cefacefeed};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic eq(input string req, input string what,
                    input logic [255:0] act, input logic [255:0] exp);
    chk(act === exp, req, what, act, exp);
  endtask

  task automatic idle_inputs();
    stall = 0; retire = 0; wbusy = 0; wdone = 0; pc = 0; insn = 0;
    rd_v = 0; wr_v = 0; rd_id = '0; wr_id = '0; rd_data = '0; wr_data = '0;
    ld_v = 0; st_v = 0; ld_addr = 0; st_addr = 0; st_mask = 0;
    ld_data = '0; st_data = '0;
  endtask

  // called at a negedge; drains beats until the stream is idle
  task automatic collect(input bit tog);
    int idle = 0;
    bit ph = 1'b1;
    nb = 0;
    for (int k = 0; k < 80; k++) begin
      t_ready = tog ? ph : 1'b1;
      ph = ~ph;
      if (t_valid && t_ready && nb < 16) begin
        b_hdr[nb] = t_hdr; b_code[nb] = t_code; b_dir[nb] = t_dir;
        b_err[nb] = t_err; b_wide[nb] = t_wide; b_last[nb] = t_last;
        b_cyc[nb] = t_cyc; b_addr[nb] = t_addr; b_aux[nb] = t_aux;
        b_data[nb] = t_data; nb++;
      end
      idle = t_valid ? 0 : idle + 1;
      if (idle >= 4) break;
      @(negedge clk);
    end
    t_ready = 1'b0;
  endtask

  task automatic fire(input bit tog);
    exp_cyc = cyc;
    @(negedge clk);
    idle_inputs();
    collect(tog);
  endtask

  task automatic beat(input int i, input string req, input bit hdr, input logic [1:0] code,
                      input bit dir, input bit wide, input bit err, input bit last,
                      input logic [31:0] addr, input logic [31:0] aux, input logic [255:0] data);
    eq(req, $sformatf("beat%0d hdr", i), 256'(b_hdr[i]), 256'(hdr));
    eq(req, $sformatf("beat%0d code", i), 256'(b_code[i]), 256'(code));
    eq(req, $sformatf("beat%0d dir", i), 256'(b_dir[i]), 256'(dir));
    eq(req, $sformatf("beat%0d wide", i), 256'(b_wide[i]), 256'(wide));
    eq("R9", $sformatf("beat%0d err", i), 256'(b_err[i]), 256'(err));
    eq("R10", $sformatf("beat%0d last", i), 256'(b_last[i]), 256'(last));
    eq("R2", $sformatf("beat%0d cycle", i), 256'(b_cyc[i]), 256'(exp_cyc));
    eq(req, $sformatf("beat%0d addr", i), 256'(b_addr[i]), 256'(addr));
    eq(req, $sformatf("beat%0d aux", i), 256'(b_aux[i]), 256'(aux));
    eq(req, $sformatf("beat%0d data", i), b_data[i], data);
  endtask

  task automatic t_reset();
    eq("R1", "valid after reset", 256'(t_valid), 256'(0));
    eq("R1", "ovf after reset", 256'(ovf), 256'(0));
  endtask

  task automatic t_stall_exec();
    stall = 1; pc = 32'h14c; insn = 32'h01800d13;
    fire(0);
    eq("R2", "stall beats", 256'(nb), 256'(1));
    beat(0, "R3", 1, 2'd0, 0, 0, 0, 1, 32'h14c, 32'h01800d13, '0);
    retire = 1; pc = 32'h158; insn = 32'h01acd08b;
    rd_v = 2'b11; rd_id[0] = 7'h05; rd_data[0] = {8{32'hdeadbeef}};
    rd_id[1] = 7'h60; rd_data[1] = '1;
    wr_v = 2'b11; wr_id[0] = 7'h23; wr_data[0] = D1; wr_id[1] = 7'h40; wr_data[1] = D2;
    st_v = 1; st_addr = 32'h20; st_mask = '1; st_data = D1;
    fire(0);
    eq("R5", "exec beats", 256'(nb), 256'(6));
    beat(0, "R3", 1, 2'd1, 0, 0, 0, 0, 32'h158, 32'h01acd08b, '0);
    beat(1, "R6", 0, 2'd1, 0, 0, 0, 0, 32'h05, 0, 256'hdeadbeef);
    beat(2, "R6", 0, 2'd1, 0, 0, 0, 0, 32'h60, 0, 256'hf);
    beat(3, "R5", 0, 2'd1, 1, 0, 0, 0, 32'h23, 0, D1);
    beat(4, "R6", 0, 2'd1, 1, 0, 0, 0, 32'h40, 0, D2);
    beat(5, "R7", 0, 2'd2, 1, 1, 0, 1, 32'h20, 0, D1);
  endtask

  task automatic t_wipe();
    wbusy = 1;
    fire(0);
    eq("R3", "wipe busy beats", 256'(nb), 256'(1));
    beat(0, "R3", 1, 2'd2, 0, 0, 0, 1, 0, 0, '0);
    wdone = 1;
    fire(0);
    eq("R3", "wipe done beats", 256'(nb), 256'(1));
    beat(0, "R3", 1, 2'd3, 0, 0, 0, 1, 0, 0, '0);
  endtask

  task automatic t_multi_hdr();
    stall = 1; retire = 1; wdone = 1; pc = 32'h150; insn = 32'h01acc10b;
    fire(1);
    eq("R4", "multi header beats", 256'(nb), 256'(3));
    beat(0, "R4", 1, 2'd0, 0, 0, 0, 0, 32'h150, 32'h01acc10b, '0);
    beat(1, "R4", 1, 2'd1, 0, 0, 0, 0, 32'h150, 32'h01acc10b, '0);
    beat(2, "R4", 1, 2'd3, 0, 0, 0, 1, 0, 0, '0);
  endtask

  task automatic t_no_hdr();
    ld_v = 1; ld_addr = 32'h40; ld_data = D2;
    fire(1);
    eq("R4", "headerless beats", 256'(nb), 256'(1));
    beat(0, "R7", 0, 2'd2, 0, 1, 0, 1, 32'h40, 0, D2);
  endtask

  task automatic t_stores();
    st_v = 1; st_addr = 32'h40; st_mask = 32'h0000f000; st_data = D2;
    fire(0);
    eq("R8", "narrow beats", 256'(nb), 256'(1));
    beat(0, "R8", 0, 2'd2, 1, 0, 0, 1, 32'h4c, 0, 256'(D2[127:96]));
    st_v = 1; st_addr = 32'h80; st_mask = 32'h00000ff0; st_data = D1;
    fire(0);
    eq("R9", "bad mask beats", 256'(nb), 256'(1));
    beat(0, "R9", 0, 2'd2, 1, 0, 1, 1, 32'h80, 32'h00000ff0, D1);
  endtask

  task automatic t_quiet();
    repeat (3) @(negedge clk);
    collect(0);
    eq("R2", "quiet cycle beats", 256'(nb), 256'(0));
  endtask

  task automatic t_overflow();
    logic [31:0] s;
    wbusy = 1;
    s = cyc;
    repeat (5) @(negedge clk);
    idle_inputs();
    eq("R11", "ovf after drop", 256'(ovf), 256'(1));
    collect(1);
    eq("R11", "kept records", 256'(nb), 256'(4));
    for (int i = 0; i < 4; i++)
      eq("R12", $sformatf("record%0d stamp", i), 256'(b_cyc[i]), 256'(s + 32'(i)));
    eq("R11", "ovf held after drain", 256'(ovf), 256'(1));
    ovf_clr = 1;
    @(negedge clk);
    ovf_clr = 0;
    eq("R11", "ovf after clear", 256'(ovf), 256'(0));
  endtask

  bit finished = 0;
  initial begin
    idle_inputs();
    ovf_clr = 0;
    t_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_stall_exec();
    t_wipe();
    t_multi_hdr();
    t_no_hdr();
    t_stores();
    t_quiet();
    t_overflow();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule